// File: doc/BRIEF.md
# Configuration Window Decoder for a PCIe Host Bridge

This block decodes the memory-mapped configuration window of a PCIe host bridge. Software programs a 64-bit window control register through a 32-bit configuration write port with per-byte enables. From that register the block derives four things: whether the window is live, the window base, the window size (256, 128 or 64 MiB), and the bounds of the PCI memory hole that sits above the window.

Each incoming memory address is compared with the live window. On a hit, the offset inside the window is split into the bus, device, function and register fields used for configuration routing. A small update state machine recomputes the derived window settings after reset and after every configuration write that touches the control register. It has three states:
- ST_BOOT: the first cycle after reset. The settings are computed from the reset value.
- ST_IDLE: the settings are held.
- ST_APPLY: the settings are reloaded from the register.

Its transitions are:
- BOOT→IDLE.
- BOOT→APPLY, IDLE→APPLY and APPLY→APPLY, each on an overlapping write.
- APPLY→IDLE when no overlapping write arrives.

Top module: `ecam_window_decoder`

## Requirements
- R1: Register bit 0 is the window enable. While the enable reads 0, `win_hit` stays 0 for every address.
- R2: Register bits 2:1 select the size: 00 = 256 MiB, 01 = 128 MiB, 10 = 64 MiB. With a valid size and the enable set, `win_hit` is 1 exactly for addresses with base <= addr < base + size.
- R3: Size code 11 is reserved. It drives `len_err` to 1 and the window is treated as not live: no hit, and the hole is placed as in R6.
- R4: The significant base bits depend on the size. Bits 35:28 are always significant. Bit 27 is also significant for 128 MiB. Bits 27:26 are significant for 64 MiB. Stored base bits that are not significant are ignored for the match.
- R5: When the window is live, `hole_lo` equals base + size and `hole_hi` equals 0xFEBF_FFFF.
- R6: When the window is not live, `hole_lo` equals 0xB000_0000 (the default base) and `hole_hi` equals 0xFEBF_FFFF.
- R7: After reset, the register reads back as 0x0000_0000_B000_0000: 256 MiB, disabled. `win_hit` and `len_err` are 0 and `hole_lo` is 0xB000_0000.
- R8: The register occupies dword index 24 (bits 31:0) and dword index 25 (bits 63:32) of the configuration port. Only bytes with their enable set are written. Bits 25:3 and 63:36 always read 0.
- R9: The derived outputs take new values one cycle after the write edge, that is, on the following rising edge. A write to any other dword, or a write with no byte enable set, changes neither the register nor the outputs.
- R10: On a hit, with offset = addr − base: `win_bus` = offset[27:20], `win_dev` = offset[19:15], `win_fn` = offset[14:12] and `win_reg` = offset[11:0]. Smaller windows therefore zero the top bus bits. On a miss all four fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration dword index (read and write) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (0 outside the register) |
| mem_addr | input | 36 | Memory address to decode |
| win_hit | output | 1 | Address falls in the live window |
| win_bus | output | 8 | Bus number of a hit |
| win_dev | output | 5 | Device number of a hit |
| win_fn | output | 3 | Function number of a hit |
| win_reg | output | 12 | Register offset of a hit |
| len_err | output | 1 | Reserved size code selected |
| hole_lo | output | 37 | First byte of the PCI hole |
| hole_hi | output | 37 | Last byte of the PCI hole |

## Verification
The assertions take for granted three things about the inputs:
- The write strobe is low while reset is asserted.
- The inputs never carry X or Z.
- The memory address is only meaningful within its 36 bits.

The enable property looks one cycle back at the write strobe. It therefore relies on writes being single-cycle strobes sampled on a clean edge. The stimulus meets these assumptions as follows:
- Every input is driven on the falling edge.
- The strobe is held at 0 through reset.
- Each write is pulsed for exactly one cycle.
- Random data, byte enables and dword indices are drawn so that reserved codes, partial writes and off-target writes all occur.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

    typedef enum logic [1:0] {
        LEN_256 = 2'b00,
        LEN_128 = 2'b01,
        LEN_64  = 2'b10,
        LEN_RSV = 2'b11
    } len_code_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_APPLY = 2'd2
    } upd_state_e;

    typedef struct packed {
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] regoff;
    } cfg_fields_t;

    // Number of low address bits that fall inside the window for a size code.
    function automatic int unsigned len_shift(len_code_e c);
        case (c)
            LEN_128: return 27;
            LEN_64:  return 26;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/ecam_ctrl_reg.sv
module ecam_ctrl_reg #(
    parameter int          ADDR_W       = 36,
    parameter int          CFG_AW       = 10,
    parameter int          CTRL_DW      = 24,
    parameter logic [63:0] DEFAULT_BASE = 64'h0000_0000_B000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [ADDR_W-1:0] ctrl_o,
    output logic              wr_hit_o
);

    localparam int          NBYTES    = 8;
    localparam int          LOW_BASE  = 26;
    localparam logic [63:0] ADDR_SPAN = (64'd1 << ADDR_W) - 64'd1;
    localparam logic [63:0] IMPL_MASK = (ADDR_SPAN & ~((64'd1 << LOW_BASE) - 64'd1)) | 64'd7;
    localparam logic [63:0] RESET_VAL = DEFAULT_BASE & IMPL_MASK;
    localparam logic [CFG_AW-1:0] DW_LO = CFG_AW'(CTRL_DW);
    localparam logic [CFG_AW-1:0] DW_HI = CFG_AW'(CTRL_DW + 1);

    logic [63:0] q_full;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam int          LANE = b % 4;
        localparam logic [CFG_AW-1:0] DWI = CFG_AW'(CTRL_DW + b / 4);
        localparam logic [7:0]  KEEP = IMPL_MASK[b*8 +: 8];
        localparam logic [7:0]  RSTB = RESET_VAL[b*8 +: 8];

        logic       sel;
        logic [7:0] q_b;

        assign sel = wr_en && (addr == DWI) && be[LANE];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_b <= RSTB;
            end else if (sel) begin
                q_b <= wdata[LANE*8 +: 8] & KEEP;
            end
        end

        assign q_full[b*8 +: 8] = q_b;
    end

    always_comb begin
        if (addr == DW_LO) begin
            rdata = q_full[31:0];
        end else if (addr == DW_HI) begin
            rdata = q_full[63:32];
        end else begin
            rdata = 32'd0;
        end
    end

    assign ctrl_o   = q_full[ADDR_W-1:0];
    assign wr_hit_o = wr_en && (|be) && ((addr == DW_LO) || (addr == DW_HI));

    // R8: the unimplemented low field never reads back as set
    p_readback_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == DW_LO) |-> (rdata[25:3] == 23'd0));

endmodule

// File: rtl/ecam_update_fsm.sv
module ecam_update_fsm
    import ecam_pkg::*;
#(
    parameter int          ADDR_W       = 36,
    parameter logic [63:0] DEFAULT_BASE = 64'h0000_0000_B000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit_i,
    input  logic [ADDR_W-1:0] ctrl_i,
    output logic              active_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] offmask_o,
    output logic              len_err_o,
    output logic [ADDR_W:0]   hole_lo_o
);

    localparam logic [ADDR_W-1:0] ONES      = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] RST_MASK  = ~(ONES << 28);
    localparam logic [ADDR_W-1:0] RST_BASE  = DEFAULT_BASE[ADDR_W-1:0] & ~RST_MASK;
    localparam logic [ADDR_W:0]   DEF_HOLE  = DEFAULT_BASE[ADDR_W:0];

    upd_state_e        state_q, state_d;
    len_code_e         len;
    logic              act_n, rsv_n;
    logic [ADDR_W-1:0] mask_n, base_n;
    logic [ADDR_W:0]   hole_n;

    // Combinational view of what the register currently selects
    always_comb begin
        len    = len_code_e'(ctrl_i[2:1]);
        rsv_n  = (len == LEN_RSV);
        act_n  = ctrl_i[0] && !rsv_n;
        mask_n = ~(ONES << len_shift(len));
        base_n = ctrl_i & ~mask_n;
        hole_n = act_n ? ({1'b0, base_n} + {1'b0, mask_n} + {{ADDR_W{1'b0}}, 1'b1})
                       : DEF_HOLE;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = wr_hit_i ? ST_APPLY : ST_IDLE;
            ST_IDLE:  state_d = wr_hit_i ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_d = wr_hit_i ? ST_APPLY : ST_IDLE;
            default:  state_d = ST_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers: reload in BOOT and APPLY, hold in IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_o  <= 1'b0;
            base_o    <= RST_BASE;
            offmask_o <= RST_MASK;
            len_err_o <= 1'b0;
            hole_lo_o <= DEF_HOLE;
        end else begin
            unique case (state_q)
                ST_BOOT, ST_APPLY: begin
                    active_o  <= act_n;
                    base_o    <= base_n;
                    offmask_o <= mask_n;
                    len_err_o <= rsv_n;
                    hole_lo_o <= hole_n;
                end
                ST_IDLE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R9: an overlapping write always schedules a recompute
    p_apply_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_i |=> (state_q == ST_APPLY));

    // R9: while idle the derived settings do not move
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(hole_lo_o) && $stable(active_o) && $stable(base_o)));

endmodule

// File: rtl/ecam_addr_decode.sv
module ecam_addr_decode
    import ecam_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              active_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offmask_i,
    output logic              hit_o,
    output cfg_fields_t       fields_o
);

    localparam int OFF_W = 28;

    logic [OFF_W-1:0] off;

    always_comb begin
        hit_o    = active_i && ((addr_i & ~offmask_i) == base_i);
        off      = addr_i[OFF_W-1:0] & offmask_i[OFF_W-1:0];
        fields_o = '0;
        if (hit_o) begin
            fields_o.bus    = off[27:20];
            fields_o.dev    = off[19:15];
            fields_o.fn     = off[14:12];
            fields_o.regoff = off[11:0];
        end
    end

    // R2: a hit lies inside [base, base + size)
    p_hit_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((addr_i >= base_i) && ((addr_i - base_i) <= offmask_i)));

endmodule

// File: rtl/ecam_window_decoder.sv
module ecam_window_decoder
    import ecam_pkg::*;
#(
    parameter int          ADDR_W       = 36,
    parameter int          CFG_AW       = 10,
    parameter int          CTRL_DW      = 24,
    parameter logic [63:0] DEFAULT_BASE = 64'h0000_0000_B000_0000,
    parameter logic [31:0] HOLE_TOP     = 32'hFEC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              win_hit,
    output logic [7:0]        win_bus,
    output logic [4:0]        win_dev,
    output logic [2:0]        win_fn,
    output logic [11:0]       win_reg,
    output logic              len_err,
    output logic [ADDR_W:0]   hole_lo,
    output logic [ADDR_W:0]   hole_hi
);

    localparam logic [ADDR_W:0] HOLE_LAST = (ADDR_W+1)'(HOLE_TOP - 32'd1);

    logic [ADDR_W-1:0] ctrl_q;
    logic              wr_hit;
    logic              active;
    logic [ADDR_W-1:0] base, offmask;
    cfg_fields_t       fields;

    ecam_ctrl_reg #(
        .ADDR_W      (ADDR_W),
        .CFG_AW      (CFG_AW),
        .CTRL_DW     (CTRL_DW),
        .DEFAULT_BASE(DEFAULT_BASE)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .ctrl_o  (ctrl_q),
        .wr_hit_o(wr_hit)
    );

    ecam_update_fsm #(
        .ADDR_W      (ADDR_W),
        .DEFAULT_BASE(DEFAULT_BASE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit_i (wr_hit),
        .ctrl_i   (ctrl_q),
        .active_o (active),
        .base_o   (base),
        .offmask_o(offmask),
        .len_err_o(len_err),
        .hole_lo_o(hole_lo)
    );

    ecam_addr_decode #(
        .ADDR_W(ADDR_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (mem_addr),
        .active_i (active),
        .base_i   (base),
        .offmask_i(offmask),
        .hit_o    (win_hit),
        .fields_o (fields)
    );

    assign win_bus = fields.bus;
    assign win_dev = fields.dev;
    assign win_fn  = fields.fn;
    assign win_reg = fields.regoff;
    assign hole_hi = HOLE_LAST;

    // R1: with the stored enable clear and no write in flight, nothing hits
    p_no_hit_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_hit) && !ctrl_q[0]) |-> !win_hit);

    // R3: a reserved size code never yields a hit
    p_reserved_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !win_hit);

    // R5: a live window puts the hole start above its base
    p_hole_above_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (hole_lo > {1'b0, base}));

endmodule

// File: tb/ecam_window_decoder_tb.sv
module ecam_window_decoder_tb;

    localparam int          AW    = 36;
    localparam logic [63:0] IMPL  = (((64'd1 << AW) - 64'd1) & ~((64'd1 << 26) - 64'd1)) | 64'd7;
    localparam logic [36:0] DEFH  = 37'h0_B000_0000;
    localparam logic [36:0] HTOP  = 37'h0_FEBF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [9:0]  cfg_addr = 10'd0;
    logic [3:0]  cfg_be = 4'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic [35:0] mem_addr = 36'd0;
    logic        win_hit;
    logic [7:0]  win_bus;
    logic [4:0]  win_dev;
    logic [2:0]  win_fn;
    logic [11:0] win_reg;
    logic        len_err;
    logic [36:0] hole_lo, hole_hi;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [63:0] sh = 64'h0000_0000_B000_0000;

    always #5 clk = ~clk;

    ecam_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .win_hit(win_hit), .win_bus(win_bus),
        .win_dev(win_dev), .win_fn(win_fn), .win_reg(win_reg),
        .len_err(len_err), .hole_lo(hole_lo), .hole_hi(hole_hi)
    );

    function automatic bit m_rsv();
        return sh[2:1] == 2'b11;
    endfunction
    function automatic bit m_active();
        return sh[0] && !m_rsv();
    endfunction
    function automatic int m_shift();
        case (sh[2:1])
            2'b01:   return 27;
            2'b10:   return 26;
            default: return 28;
        endcase
    endfunction
    function automatic logic [36:0] m_size();
        return 37'd1 << m_shift();
    endfunction
    function automatic logic [35:0] m_base();
        return sh[35:0] & ~((36'd1 << m_shift()) - 36'd1);
    endfunction
    function automatic logic [36:0] m_hole();
        return m_active() ? ({1'b0, m_base()} + m_size()) : DEFH;
    endfunction
    function automatic string hit_tag();
        if (!sh[0]) return "R1";
        if (m_rsv()) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Write one dword; returns at the falling edge after the recompute edge
    task automatic do_write(input logic [9:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        for (int b = 0; b < 4; b++) begin
            if (be[b] && (dw == 10'd24 || dw == 10'd25)) begin
                int idx;
                idx = (dw == 10'd25) ? 4 + b : b;
                sh[idx*8 +: 8] = d[b*8 +: 8] & IMPL[idx*8 +: 8];
            end
        end
        @(negedge clk);
    endtask

    task automatic rd_check(input string tag);
        cfg_addr = 10'd24; #1;
        check(tag, {32'd0, cfg_rdata}, {32'd0, sh[31:0]});
        cfg_addr = 10'd25; #1;
        check(tag, {32'd0, cfg_rdata}, {32'd0, sh[63:32]});
    endtask

    task automatic probe(input logic [35:0] a);
        logic        eh;
        logic [35:0] off;
        logic [27:0] eo;
        mem_addr = a; #1;
        eh  = m_active() && (a >= m_base()) && ({1'b0, a} < {1'b0, m_base()} + m_size());
        off = a - m_base();
        eo  = eh ? off[27:0] : 28'd0;
        check(hit_tag(), {63'd0, win_hit}, {63'd0, eh});
        check("R10", {36'd0, win_bus, win_dev, win_fn, win_reg}, {36'd0, eo});
    endtask

    task automatic state_check(input string tag);
        check(tag, {27'd0, hole_lo}, {27'd0, m_hole()});
        check(tag, {27'd0, hole_hi}, {27'd0, HTOP});
        check("R3", {63'd0, len_err}, {63'd0, m_rsv()});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] prev;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: reset state
        rd_check("R7");
        check("R7", {27'd0, hole_lo}, {27'd0, DEFH});
        check("R7", {63'd0, len_err}, 64'd0);
        probe(36'h0_B000_0000);
        check("R7", {63'd0, win_hit}, 64'd0);

        // R9: latency of one cycle after the write edge
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 10'd24; cfg_be = 4'hF; cfg_wdata = 32'hE000_0001;
        mem_addr = 36'h0_E000_0000;
        @(negedge clk);
        cfg_wr_en = 1'b0; #1;
        check("R9", {63'd0, win_hit}, 64'd0);
        sh[31:0] = 32'hE000_0001;
        @(negedge clk); #1;
        check("R9", {63'd0, win_hit}, 64'd1);

        // R2 / R10 / R5 directed
        probe(36'h0_E000_0000 | (36'd3 << 20) | (36'd5 << 15) | (36'd2 << 12) | 36'h34);
        check("R10", {56'd0, win_bus}, 64'd3);
        check("R10", {59'd0, win_dev}, 64'd5);
        probe(36'h0_EFFF_FFFF);
        probe(36'h0_F000_0000);
        probe(36'h0_DFFF_FFFF);
        state_check("R5");
        check("R5", {27'd0, hole_lo}, 64'h0_F000_0000);

        // R8: upper dword, partial bytes, unimplemented bits
        do_write(10'd25, 4'h1, 32'hFFFF_FF0A);
        rd_check("R8");
        check("R8", {32'd0, sh[63:32]}, 64'hA);
        probe(36'hA_E000_0010);
        do_write(10'd25, 4'hF, 32'hFFFF_FFFF);
        rd_check("R8");
        do_write(10'd25, 4'hF, 32'h0);
        do_write(10'd24, 4'hF, 32'hFFFF_FFFF);
        cfg_addr = 10'd24; #1;
        check("R8", {32'd0, cfg_rdata}, 64'hFC00_0007);
        state_check("R3");

        // R4: base significance per size
        do_write(10'd24, 4'hF, 32'hEC00_0001);
        probe(36'h0_E000_0000);
        check("R4", {63'd0, win_hit}, 64'd1);
        do_write(10'd24, 4'h1, 32'h0000_0003);
        probe(36'h0_E000_0000);
        check("R4", {63'd0, win_hit}, 64'd0);
        probe(36'h0_E800_0000);
        check("R4", {63'd0, win_hit}, 64'd1);
        do_write(10'd24, 4'h1, 32'h0000_0005);
        probe(36'h0_EC00_0000);
        check("R4", {63'd0, win_hit}, 64'd1);
        probe(36'h0_EBFF_FFFF);
        probe(36'h0_F000_0000);
        state_check("R5");

        // R3: reserved code
        do_write(10'd24, 4'hF, 32'hE000_0007);
        probe(36'h0_E000_0000);
        state_check("R3");
        check("R3", {27'd0, hole_lo}, {27'd0, DEFH});

        // R1 / R6: disabled window
        do_write(10'd24, 4'hF, 32'hE000_0000);
        probe(36'h0_E000_0000);
        state_check("R6");
        check("R6", {27'd0, hole_lo}, {27'd0, DEFH});

        // R9: writes that must have no effect
        do_write(10'd24, 4'hF, 32'hE000_0001);
        prev = sh;
        do_write(10'd23, 4'hF, 32'h0000_0000);
        do_write(10'd24, 4'h0, 32'h0000_0000);
        rd_check("R9");
        check("R9", sh, prev);
        probe(36'h0_E000_1000);
        check("R9", {63'd0, win_hit}, 64'd1);

        // Random phase
        for (int i = 0; i < 300; i++) begin
            logic [9:0]  dw;
            logic [35:0] ra;
            int          sel;
            sel = int'($urandom_range(0, 9));
            dw  = (sel < 5) ? 10'd24 : (sel < 8) ? 10'd25 : 10'($urandom_range(0, 1023));
            if (dw == 10'd25 && ($urandom_range(0, 1) == 1)) begin
                do_write(dw, 4'($urandom()), {28'd0, 4'($urandom())});
            end else begin
                do_write(dw, 4'($urandom()), $urandom());
            end
            rd_check("R8");
            state_check(m_active() ? "R5" : "R6");
            ra = {4'($urandom()), $urandom()};
            probe(ra);
            probe(m_base());
            probe(m_base() + (36'($urandom()) & ((36'd1 << m_shift()) - 36'd1)));
            probe(m_base() + 36'(m_size()) - 36'd1);
            probe(m_base() + 36'(m_size()));
            probe(m_base() - 36'd1);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule